// File: doc/BRIEF.md
# DMA Command Packet Executor

This block takes six-word DMA command packets from a 32-bit valid/ready stream and carries out each transfer on a word-wide memory port that uses a request/acknowledge handshake. A transfer either copies words from a source address or fills the destination with the immediate word carried in the packet. Before each write, the block can swap bytes on the source side and on the destination side. For each side it also chooses whether the address moves forward or stays fixed. A packet can ask for a completion pulse, which is raised once the final write of that packet has been acknowledged.

Packets whose header carries an unknown opcode are drained from the stream and dropped, and an error pulse reports them. Source and destination selections that name register space or on-chip storage are accepted, but the block treats them as ordinary memory addresses.

Top module: `dma_pkt_exec`

## Requirements
- R1: A header word with opcode 0x41 in bits 15:8 starts a packet of that header plus five body words. Each word is taken on a cycle where both pktValid and pktReady are high.
- R2: A header with any other opcode is dropped together with the next (header[29:16] + 1) words. badPkt is high for exactly one cycle, the cycle after the header is taken, and no memory access results.
- R3: When body word 2 bits 30:29 are not 2, the block copies. It reads from byte address {word2[7:0], body word 1} and writes to byte address {word4[7:0], word3}. It moves floor(word5[20:0] / 4) words, so byte-count bits 1:0 are ignored, and each address steps by 4 after each access.
- R4: When body word 2 bits 30:29 equal 2, the block fills. Body word 1 is written to every destination word and memory is never read.
- R5: Word5 bits 24:23 set the source swap. A value of 1 swaps the bytes inside each 16-bit half. A value of 2 reverses the four bytes of each word. A value of 0 leaves the data unchanged.
- R6: Word5 bits 25:24 set the destination swap, with the same encoding as R5. It is applied after the source swap. Bit 24 belongs to both fields.
- R7: When either swap field equals 3, words are handled in pairs. The lower address receives the byte-reversed upper word and the upper address receives the byte-reversed lower word. An unpaired last word does not get the 64-bit swap.
- R8: When word5 bit 28 is set, the source address does not advance. When word5 bit 29 is set, the destination address does not advance.
- R9: When word2 bit 31 is set, xferDone is high for one cycle, the cycle after the final write acknowledge. If the packet moves zero words, xferDone still pulses and no memory access occurs. When bit 31 is clear, xferDone stays low.
- R10: While memReq is high and memAck is low, memReq, memWe, memAddr and memWdata all hold their values.
- R11: pktReady is low from the moment a valid packet's last body word is taken until its transfer finishes.
- R12: During reset, pktReady is high and memReq, xferDone and badPkt are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pktData | input | 32 | Packet stream word |
| pktValid | input | 1 | Packet word present |
| pktReady | output | 1 | Block accepts a packet word |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Access is a write |
| memAddr | output | ADDR_W | Byte address of the access |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid while memAck is high |
| memAck | input | 1 | Access completed |
| xferDone | output | 1 | Completion pulse for packets that requested it |
| badPkt | output | 1 | Pulse for a dropped packet with an unknown opcode |

## Verification
Copy transfers use several word counts, including a byte count that is not a multiple of four, and run against a memory whose every word differs. These runs separate correct address stepping from off-by-one and stuck addresses. Swap-field combinations are chosen to reach each field value, and they include the overlap at bit 24. One case uses an odd length, so the 64-bit pairing and its unpaired last word are visible at the destination. Runs with the source hold bit set and with the destination hold bit set show which side stays fixed. A junk word shaped like a valid header is placed inside a rejected packet; it shows whether the drain count is honoured. A zero-length packet with sync set checks that the completion pulse appears without any memory traffic.

// File: rtl/dma_pkt_pkg.sv
package dma_pkt_pkg;
  localparam logic [7:0] OPC_DMA = 8'h41;
  localparam int BODY_LAST = 4;

  typedef enum logic [3:0] {
    S_IDLE, S_BODY, S_SKIP, S_START, S_RD0, S_RD1, S_WR0, S_WR1, S_FIN
  } stateT;

  typedef struct packed {
    logic       capBody;
    logic [2:0] bodyIdx;
    logic       cap0;
    logic       cap1;
    logic       srcStep;
    logic       dstStep;
    logic       beatDone;
    logic       selHi;
  } strobeT;

  function automatic logic [31:0] revBytes(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  // returns {hi, lo}
  function automatic logic [63:0] swapPair(input logic [1:0] mode, input logic paired,
                                           input logic [31:0] lo, input logic [31:0] hi);
    logic [63:0] r;
    case (mode)
      2'd1: r = {hi[23:16], hi[31:24], hi[7:0], hi[15:8], lo[23:16], lo[31:24], lo[7:0], lo[15:8]};
      2'd2: r = {revBytes(hi), revBytes(lo)};
      2'd3: r = paired ? {revBytes(lo), revBytes(hi)} : {hi, lo};
      default: r = {hi, lo};
    endcase
    return r;
  endfunction
endpackage

// File: rtl/dmaPktCtrl.sv
module dmaPktCtrl
  import dma_pkt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  hdrOpc,
  input  logic [13:0] hdrLen,
  input  logic        pktValid,
  output logic        pktReady,
  output logic        memReq,
  output logic        memWe,
  input  logic        memAck,
  input  logic        fillMode,
  input  logic        syncReq,
  input  logic        beat2,
  input  logic        wordsZero,
  input  logic        lastBeat,
  output strobeT      stb,
  output logic        xferDone,
  output logic        badPkt
);
  stateT       state, stateNext;
  logic [2:0]  bodyIdx;
  logic [14:0] skipCnt;
  logic        errQ;

  wire hdrTake = (state == S_IDLE) && pktValid;
  wire hdrOk   = (hdrOpc == OPC_DMA);

  assign pktReady = (state == S_IDLE) || (state == S_BODY) || (state == S_SKIP);
  assign memWe    = (state == S_WR0) || (state == S_WR1);
  assign memReq   = memWe || (((state == S_RD0) || (state == S_RD1)) && !fillMode);
  assign xferDone = (state == S_FIN) && syncReq;
  assign badPkt   = errQ;

  always_comb begin
    stateNext = state;
    stb = '0;
    stb.bodyIdx = bodyIdx;
    stb.selHi = (state == S_WR1);
    case (state)
      S_IDLE: if (pktValid) stateNext = hdrOk ? S_BODY : S_SKIP;
      S_SKIP: if (pktValid && skipCnt == 15'd1) stateNext = S_IDLE;
      S_BODY: if (pktValid) begin
        stb.capBody = 1'b1;
        if (bodyIdx == 3'(BODY_LAST)) stateNext = S_START;
      end
      S_START: stateNext = wordsZero ? S_FIN : S_RD0;
      S_RD0: if (fillMode || memAck) begin
        stb.cap0 = 1'b1;
        stb.srcStep = !fillMode;
        stateNext = beat2 ? S_RD1 : S_WR0;
      end
      S_RD1: if (fillMode || memAck) begin
        stb.cap1 = 1'b1;
        stb.srcStep = !fillMode;
        stateNext = S_WR0;
      end
      S_WR0: if (memAck) begin
        stb.dstStep = 1'b1;
        if (beat2) stateNext = S_WR1;
        else begin
          stb.beatDone = 1'b1;
          stateNext = lastBeat ? S_FIN : S_RD0;
        end
      end
      S_WR1: if (memAck) begin
        stb.dstStep = 1'b1;
        stb.beatDone = 1'b1;
        stateNext = lastBeat ? S_FIN : S_RD0;
      end
      S_FIN: stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      bodyIdx <= '0;
      skipCnt <= '0;
      errQ    <= 1'b0;
    end else begin
      state <= stateNext;
      errQ  <= hdrTake && !hdrOk;
      if (hdrTake) begin
        bodyIdx <= '0;
        skipCnt <= {1'b0, hdrLen} + 15'd1;
      end
      if (stb.capBody) bodyIdx <= bodyIdx + 3'd1;
      if (state == S_SKIP && pktValid) skipCnt <= skipCnt - 15'd1;
    end
  end

  // R10: an outstanding request keeps its kind until acknowledged
  p_req_held_r10: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memWe));
  // R9: completion is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |=> !xferDone);
  // R11: no intake while memory traffic is in flight
  p_intake_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    pktReady |-> !memReq);
  // R2: error pulse lasts one cycle
  p_err_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    badPkt |=> !badPkt);
endmodule

// File: rtl/dmaPktPath.sv
module dmaPktPath
  import dma_pkt_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int CNT_W  = 21
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [31:0]       pktData,
  input  strobeT            stb,
  input  logic              memReq,
  input  logic              memWe,
  input  logic              memAck,
  input  logic [31:0]       memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  output logic              fillMode,
  output logic              syncReq,
  output logic              beat2,
  output logic              wordsZero,
  output logic              lastBeat
);
  localparam int WL_W = CNT_W - 2;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  logic [31:0]       immWord, dstLo, d0, d1;
  logic [7:0]        srcHi, dstHi;
  logic [1:0]        srcSel, srcSw, dstSw;
  logic              srcHold, dstHold;
  logic [ADDR_W-1:0] srcAddr, dstAddr;
  logic [WL_W-1:0]   wordsLeft;
  logic [63:0]       srcSwapped, dstSwapped;

  wire loadAll  = stb.capBody && (stb.bodyIdx == 3'(BODY_LAST));
  wire pairMode = (srcSw == 2'd3) || (dstSw == 2'd3);

  assign fillMode  = (srcSel == 2'd2);
  assign beat2     = pairMode && (wordsLeft >= WL_W'(2));
  assign wordsZero = (wordsLeft == '0);
  assign lastBeat  = (wordsLeft == (beat2 ? WL_W'(2) : WL_W'(1)));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      immWord <= '0; dstLo <= '0; srcHi <= '0; dstHi <= '0;
      srcSel <= '0; syncReq <= 1'b0; srcSw <= '0; dstSw <= '0;
      srcHold <= 1'b0; dstHold <= 1'b0;
      srcAddr <= '0; dstAddr <= '0; wordsLeft <= '0;
      d0 <= '0; d1 <= '0;
    end else begin
      if (stb.capBody) begin
        case (stb.bodyIdx)
          3'd0: immWord <= pktData;
          3'd1: begin
            syncReq <= pktData[31];
            srcSel  <= pktData[30:29];
            srcHi   <= pktData[7:0];
          end
          3'd2: dstLo <= pktData;
          3'd3: dstHi <= pktData[7:0];
          default: begin
            srcSw   <= pktData[24:23];
            dstSw   <= pktData[25:24];
            srcHold <= pktData[28];
            dstHold <= pktData[29];
          end
        endcase
      end
      if (loadAll) begin
        srcAddr   <= ADDR_W'({srcHi, immWord});
        dstAddr   <= ADDR_W'({dstHi, dstLo});
        wordsLeft <= pktData[CNT_W-1:2];
      end else if (stb.beatDone) begin
        wordsLeft <= wordsLeft - (beat2 ? WL_W'(2) : WL_W'(1));
      end
      if (stb.srcStep && !srcHold) srcAddr <= srcAddr + STEP;
      if (stb.dstStep && !dstHold) dstAddr <= dstAddr + STEP;
      if (stb.cap0) d0 <= fillMode ? immWord : memRdata;
      if (stb.cap1) d1 <= fillMode ? immWord : memRdata;
    end
  end

  always_comb begin
    srcSwapped = swapPair(srcSw, beat2, d0, d1);
    dstSwapped = swapPair(dstSw, beat2, srcSwapped[31:0], srcSwapped[63:32]);
  end

  assign memAddr  = memWe ? dstAddr : srcAddr;
  assign memWdata = stb.selHi ? dstSwapped[63:32] : dstSwapped[31:0];

  // R10: address and data hold while a request waits
  p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> $stable(memAddr) && $stable(memWdata));
  // R3: a finished beat never takes more words than remain
  p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.beatDone |-> wordsLeft >= (beat2 ? WL_W'(2) : WL_W'(1)));
endmodule

// File: rtl/dma_pkt_exec.sv
module dma_pkt_exec
  import dma_pkt_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int CNT_W  = 21
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [31:0]       pktData,
  input  logic              pktValid,
  output logic              pktReady,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata,
  input  logic              memAck,
  output logic              xferDone,
  output logic              badPkt
);
  strobeT stb;
  logic fillMode, syncReq, beat2, wordsZero, lastBeat;

  dmaPktCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .hdrOpc(pktData[15:8]), .hdrLen(pktData[29:16]),
    .pktValid(pktValid), .pktReady(pktReady), .memReq(memReq), .memWe(memWe),
    .memAck(memAck), .fillMode(fillMode), .syncReq(syncReq), .beat2(beat2),
    .wordsZero(wordsZero), .lastBeat(lastBeat), .stb(stb),
    .xferDone(xferDone), .badPkt(badPkt)
  );

  dmaPktPath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_path (
    .clk(clk), .rstN(rstN), .pktData(pktData), .stb(stb), .memReq(memReq),
    .memWe(memWe), .memAck(memAck), .memRdata(memRdata), .memAddr(memAddr),
    .memWdata(memWdata), .fillMode(fillMode), .syncReq(syncReq), .beat2(beat2),
    .wordsZero(wordsZero), .lastBeat(lastBeat)
  );
endmodule

// File: tb/test_dma_pkt_exec.sv
module test_dma_pkt_exec;
  localparam int ADDR_W = 40;
  logic clk = 1'b0, rstN = 1'b0;
  logic [31:0] pktData = '0, memRdata = '0, memWdata;
  logic pktValid = 1'b0, pktReady, memReq, memWe, memAck = 1'b0, xferDone, badPkt;
  logic [ADDR_W-1:0] memAddr;

  always #4 clk = ~clk;

  dma_pkt_exec #(.ADDR_W(ADDR_W)) i_dma_pkt_exec (
    .clk(clk), .rstN(rstN), .pktData(pktData), .pktValid(pktValid), .pktReady(pktReady),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memAck(memAck), .xferDone(xferDone), .badPkt(badPkt)
  );

  logic [31:0] mem [0:255];
  logic [31:0] expMem [0:255];
  int checks = 0, errors = 0;
  int readCnt = 0, writeCnt = 0, doneCnt = 0, errCnt = 0, doneAfterWr = 0, hsViol = 0;
  logic wrAckPrev = 1'b0, pendPrev = 1'b0, wePrev = 1'b0;
  logic [ADDR_W-1:0] addrPrev = '0;
  logic [31:0] wdPrev = '0;

  // memory model: acknowledges one cycle after a request is seen
  always @(posedge clk) begin
    memAck <= 1'b0;
    if (rstN && memReq && !memAck) begin
      memAck <= 1'b1;
      if (memWe) begin mem[memAddr[9:2]] <= memWdata; writeCnt <= writeCnt + 1; end
      else begin memRdata <= mem[memAddr[9:2]]; readCnt <= readCnt + 1; end
    end
  end

  // event monitors
  always @(posedge clk) begin
    if (rstN) begin
      if (xferDone) begin doneCnt <= doneCnt + 1; if (wrAckPrev) doneAfterWr <= doneAfterWr + 1; end
      if (badPkt) errCnt <= errCnt + 1;
      if (pendPrev && (!memReq || memWe !== wePrev || memAddr !== addrPrev || memWdata !== wdPrev))
        hsViol <= hsViol + 1;
      wrAckPrev <= memAck && memWe;
      pendPrev <= memReq && !memAck;
      wePrev <= memWe; addrPrev <= memAddr; wdPrev <= memWdata;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic sendWord(input logic [31:0] w);
    pktData = w; pktValid = 1'b1;
    while (!pktReady) @(negedge clk);
    @(negedge clk);
    pktValid = 1'b0;
  endtask

  function automatic logic [31:0] tbRev(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction
  function automatic logic [31:0] tbOne(input logic [1:0] m, input logic [31:0] w);
    if (m == 2'd1) return {w[23:16], w[31:24], w[7:0], w[15:8]};
    if (m == 2'd2) return tbRev(w);
    return w;
  endfunction

  task automatic runXfer(input string req, input logic [1:0] sel, input int srcB, input int dstB,
                         input logic [31:0] imm, input int bc, input logic b25, input logic b24,
                         input logic b23, input logic hs, input logic hd, input logic sy);
    logic [1:0] ss, ds;
    logic pair, fill;
    logic [31:0] a, b, x0, x1;
    int n, s, d, i, expReads, r0, w0, dn0, da0, bad, firstBad;
    ss = {b24, b23}; ds = {b25, b24};
    pair = (ss == 2'd3) || (ds == 2'd3);
    fill = (sel == 2'd2);
    n = bc >> 2; s = srcB; d = dstB; i = 0; expReads = 0;
    while (i < n) begin
      a = fill ? imm : expMem[(s >> 2) & 255]; if (!fill) expReads++;
      if (!hs && !fill) s += 4;
      if (pair && (n - i) >= 2) begin
        b = fill ? imm : expMem[(s >> 2) & 255]; if (!fill) expReads++;
        if (!hs && !fill) s += 4;
        if (ss == 2'd3) begin x0 = tbRev(b); x1 = tbRev(a); end
        else begin x0 = tbOne(ss, a); x1 = tbOne(ss, b); end
        if (ds == 2'd3) begin a = tbRev(x1); b = tbRev(x0); end
        else begin a = tbOne(ds, x0); b = tbOne(ds, x1); end
        expMem[(d >> 2) & 255] = a; if (!hd) d += 4;
        expMem[(d >> 2) & 255] = b; if (!hd) d += 4;
        i += 2;
      end else begin
        expMem[(d >> 2) & 255] = tbOne(ds, tbOne(ss, a)); if (!hd) d += 4;
        i += 1;
      end
    end
    r0 = readCnt; w0 = writeCnt; dn0 = doneCnt; da0 = doneAfterWr;
    sendWord({2'b00, 14'd4, 8'h41, 8'h00});               // R1 header
    sendWord(fill ? imm : srcB);
    sendWord({sy, sel, 21'd0, 8'd0});
    sendWord(dstB);
    sendWord(32'd0);
    sendWord({2'b00, hd, hs, 2'b00, b25, b24, b23, 2'b00, bc[20:0]});
    if (n > 0) check(pktReady == 1'b0, "R11", {req, " intake closed while busy"}, pktReady, 0);
    while (!pktReady) @(negedge clk);
    @(negedge clk);
    bad = 0; firstBad = -1;
    for (int k = 0; k < 256; k++) if (mem[k] !== expMem[k]) begin bad++; if (firstBad < 0) firstBad = k; end
    if (firstBad < 0) check(1'b1, req, "memory image", 0, 0);
    else check(1'b0, req, $sformatf("memory word %0d", firstBad), mem[firstBad], expMem[firstBad]);
    check(writeCnt - w0 == n, req, "write count", writeCnt - w0, n);
    check(readCnt - r0 == expReads, req, "read count", readCnt - r0, expReads);
    check(doneCnt - dn0 == (sy ? 1 : 0), "R9", {req, " done pulses"}, doneCnt - dn0, sy ? 1 : 0);
    if (sy && n > 0)
      check(doneAfterWr - da0 == 1, "R9", {req, " done follows last write ack"}, doneAfterWr - da0, 1);
  endtask

  task automatic testReset();
    check(pktReady == 1'b1, "R12", "pktReady in reset", pktReady, 1);
    check(memReq == 1'b0, "R12", "memReq in reset", memReq, 0);
    check(xferDone == 1'b0, "R12", "xferDone in reset", xferDone, 0);
    check(badPkt == 1'b0, "R12", "badPkt in reset", badPkt, 0);
  endtask

  task automatic testBadOpcode();
    int e0, w0, r0;
    e0 = errCnt; w0 = writeCnt; r0 = readCnt;
    sendWord({2'b00, 14'd2, 8'h42, 8'h00});
    sendWord(32'h0004_4100);   // looks like a valid header, must be drained
    sendWord(32'h0004_4100);
    sendWord(32'h0004_4100);
    repeat (2) @(negedge clk);
    check(errCnt - e0 == 1, "R2", "error pulses", errCnt - e0, 1);
    check(writeCnt - w0 == 0 && readCnt - r0 == 0, "R2", "no memory traffic", writeCnt - w0 + readCnt - r0, 0);
    runXfer("R2 after drop", 2'd2, 0, 32'h3C0, 32'hDEAD_0001, 8, 0, 0, 0, 0, 0, 1);
  endtask

  initial begin
    bit timeout = 1'b0;
    for (int k = 0; k < 256; k++) begin
      mem[k] = {k[7:0], ~k[7:0], k[7:0] ^ 8'h3C, 8'hC3 + k[7:0]};
      expMem[k] = mem[k];
    end
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    fork
      begin
        runXfer("R1 R3 copy", 2'd0, 32'h100, 32'h200, 0, 35, 0, 0, 0, 0, 0, 1);
        runXfer("R3 storage select", 2'd1, 32'h040, 32'h300, 0, 12, 0, 0, 0, 0, 0, 0);
        runXfer("R4 fill", 2'd2, 0, 32'h380, 32'hA5A5_1234, 20, 0, 0, 0, 0, 0, 0);
        runXfer("R5 src swap16", 2'd0, 32'h100, 32'h140, 0, 16, 0, 0, 1, 0, 0, 1);
        runXfer("R6 dst swap32", 2'd0, 32'h180, 32'h1C0, 0, 12, 1, 0, 0, 0, 0, 0);
        runXfer("R7 src32 dst64", 2'd0, 32'h040, 32'h240, 0, 16, 1, 1, 0, 0, 0, 1);
        runXfer("R7 src64 dst16 odd", 2'd0, 32'h060, 32'h280, 0, 20, 0, 1, 1, 0, 0, 1);
        runXfer("R8 src hold", 2'd0, 32'h010, 32'h2C0, 0, 12, 0, 0, 0, 1, 0, 0);
        runXfer("R8 dst hold", 2'd2, 0, 32'h2E0, 32'h0BAD_F00D, 16, 0, 0, 0, 0, 1, 0);
        testBadOpcode();
        runXfer("R9 zero length", 2'd0, 32'h100, 32'h200, 0, 3, 0, 0, 0, 0, 0, 1);
        check(hsViol == 0, "R10", "request held until ack", hsViol, 0);
        check(errCnt == 1, "R2", "total error pulses", errCnt, 1);
      end
      begin
        repeat (100000) @(posedge clk);
        timeout = 1'b1;
      end
    join_any
    disable fork;
    if (timeout) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule